// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that advances on one of two clock sources: a one-cycle-wide internal tick (the instruction-cycle enable, one quarter of the oscillator rate) or rising edges seen on an external clock pin. The chosen source passes through a divide-by-1/2/4/8 prescaler before it reaches the count. External edges are taken either through a two-stage synchronizer, or without it for lower latency.

Software controls the block through an 8-bit control register and writes the count one byte at a time. An overflow from all-ones to zero sets a sticky flag that software clears. A special-event input from a neighbouring block forces the count to zero.

Top module: `tick_counter16`

## Requirements
- R1: With the source bit (control bit 6) at 0, the count advances once per prescaled cycle with `tick_en` high, and the external pin has no effect.
- R2: With the source bit at 1, the count advances on rising edges of `ext_clk`. Falling edges and `tick_en` have no effect.
- R3: The prescale field (control bits 1:0) divides the selected source: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /8. The count changes by at most one per clock.
- R4: With the no-sync bit (control bit 5) at 0, an external rising edge shows in the count on the third clock edge after the pin rises. With it at 1, the edge shows on the first clock edge.
- R5: With the run bit (control bit 7) at 0, the count and the prescaler hold their values.
- R6: `lo_we` and `hi_we` load `cnt_wdata` into the low and high count bytes, which read back on `cnt_lo` and `cnt_hi`. `ctl_rd` returns bits 7, 6, 5 and 1:0 as written, and the other bits read as 0.
- R7: When the count steps from 0xFFFF to 0x0000, `ovf_flag` is set, and it stays set until it is cleared.
- R8: `flag_clr` clears `ovf_flag`. An overflow in the same cycle wins, and the flag stays set.
- R9: `evt_clr` makes the count zero on the next edge, and it takes priority over an increment and over byte writes.
- R10: A write to either count byte, or a control write that changes the prescale field, restarts the prescaler from zero.
- R11: Reset clears the count, the control register, the prescaler and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rd | output | 8 | Control register readback |
| lo_we | input | 1 | Low count byte write strobe |
| hi_we | input | 1 | High count byte write strobe |
| cnt_wdata | input | 8 | Count byte write data |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ext_clk | input | 1 | External clock pin |
| tick_en | input | 1 | Internal instruction-cycle tick |
| evt_clr | input | 1 | Special-event clear |
| flag_clr | input | 1 | Software clear of the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A prescaler phase left over from an earlier setting shows up as a count that runs one step early within the first divided period after a write. A wrong synchronizer depth shows up as the count changing one or two edges away from the cycle given in R4. A flag or clear priority that is wrong is visible on the edge right after the colliding cycle. The bench sweeps every combination of source, sync mode and prescale, and compares the count with the number of edges applied shifted right by the prescale field.

// File: rtl/tick_counter16.sv
module tick_counter16 #(
  parameter int DW  = 8,
  parameter int PSW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rd,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [DW-1:0] cnt_wdata,
  output logic [DW-1:0] cnt_lo,
  output logic [DW-1:0] cnt_hi,
  input  logic          ext_clk,
  input  logic          tick_en,
  input  logic          evt_clr,
  input  logic          flag_clr,
  output logic          ovf_flag
);
  localparam int CW  = 2 * DW;
  localparam int PCW = (1 << PSW) - 1;
  localparam int B_RUN = 7;
  localparam int B_SRC = 6;
  localparam int B_ASY = 5;
  localparam logic [7:0] CTL_MASK = 8'((1 << B_RUN) | (1 << B_SRC) | (1 << B_ASY) | ((1 << PSW) - 1));

  logic [7:0]     ctl_q;
  logic [CW-1:0]  cnt_q;
  logic [PCW-1:0] psc_q;
  logic [2:0]     sy_q;
  logic           raw_q;

  wire           run = ctl_q[B_RUN];
  wire           src = ctl_q[B_SRC];
  wire           asy = ctl_q[B_ASY];
  wire [PSW-1:0] ps  = ctl_q[PSW-1:0];

  wire ext_edge = asy ? (ext_clk & ~raw_q) : (sy_q[1] & ~sy_q[2]);
  wire tick     = src ? ext_edge : tick_en;
  wire adv      = run & tick;

  wire [PCW-1:0] mask = ~({PCW{1'b1}} << ps);
  wire fire     = adv & ((psc_q & mask) == mask);
  wire byte_wr  = lo_we | hi_we;
  wire psc_rst  = byte_wr | (ctl_we && (ctl_wdata[PSW-1:0] != ps));
  wire wrap     = fire && (cnt_q == {CW{1'b1}}) && !evt_clr && !byte_wr;

  assign ctl_rd = ctl_q;
  assign cnt_lo = cnt_q[DW-1:0];
  assign cnt_hi = cnt_q[CW-1:DW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy_q  <= '0;
      raw_q <= 1'b0;
    end else begin
      sy_q  <= {sy_q[1:0], ext_clk};
      raw_q <= ext_clk;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata & CTL_MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       psc_q <= '0;
    else if (psc_rst) psc_q <= '0;
    else if (adv)     psc_q <= fire ? '0 : psc_q + PCW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt_q <= '0;
    else if (evt_clr)      cnt_q <= '0;
    else if (byte_wr) begin
      if (lo_we) cnt_q[DW-1:0]  <= cnt_wdata;
      if (hi_we) cnt_q[CW-1:DW] <= cnt_wdata;
    end else if (fire)     cnt_q <= cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap)     ovf_flag <= 1'b1;
    else if (flag_clr) ovf_flag <= 1'b0;

  p_evt_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (cnt_q == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !byte_wr && !evt_clr) |=> (cnt_q == $past(cnt_q)));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_wr && !evt_clr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1)));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);
  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CW{1'b1}} && fire && !evt_clr && !byte_wr) |=> (ovf_flag && cnt_q == '0));
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fire) |=> !ovf_flag);
  p_psc_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |=> (psc_q == '0));
endmodule

// File: tb/test_tick_counter16.sv
module test_tick_counter16;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, lo_we = 0, hi_we = 0, ext_clk = 0, tick_en = 0, evt_clr = 0, flag_clr = 0;
  logic [7:0] ctl_wdata = 0, cnt_wdata = 0, ctl_rd, cnt_lo, cnt_hi;
  logic ovf_flag;
  int total = 0, bad = 0;
  bit done = 0;

  tick_counter16 i_tick_counter16 (.clk, .rst_n, .ctl_we, .ctl_wdata, .ctl_rd, .lo_we, .hi_we,
    .cnt_wdata, .cnt_lo, .cnt_hi, .ext_clk, .tick_en, .evt_clr, .flag_clr, .ovf_flag);

  always #2 clk = ~clk;

  function automatic logic [15:0] cnt(); return {cnt_hi, cnt_lo}; endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wr_ctl(bit run, bit src, bit asy, logic [1:0] ps);
    ctl_wdata = {run, src, asy, 3'b0, ps}; ctl_we = 1; cyc(1); ctl_we = 0;
  endtask

  task automatic wr_cnt(logic [15:0] v);
    cnt_wdata = v[7:0]; lo_we = 1; cyc(1); lo_we = 0;
    cnt_wdata = v[15:8]; hi_we = 1; cyc(1); hi_we = 0;
  endtask

  task automatic pulse();
    tick_en = 1; ext_clk = 1; cyc(1); tick_en = 0; cyc(1); ext_clk = 0; cyc(2);
  endtask

  task automatic tick1(); tick_en = 1; cyc(1); tick_en = 0; endtask

  initial begin
    #200000;
    bad++; total++; $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R11 cnt", cnt(), 0); chk("R11 flag", ovf_flag, 0); chk("R11 ctl", ctl_rd, 0);
    rst_n = 1; cyc(2);

    ctl_wdata = 8'hFF; ctl_we = 1; cyc(1); ctl_we = 0;
    chk("R6 ctl readback", ctl_rd, 8'hE3);
    wr_cnt(16'h1234);
    chk("R6 lo", cnt_lo, 8'h34); chk("R6 hi", cnt_hi, 8'h12);

    for (int src = 0; src < 2; src++)
      for (int asy = 0; asy < 2; asy++)
        for (int ps = 0; ps < 4; ps++)
          for (int k = 0; k < 2; k++) begin
            automatic int n = k ? 13 : 5;
            wr_ctl(1, src[0], asy[0], ps[1:0]);
            wr_cnt(0);
            repeat (n) pulse();
            cyc(5);
            chk(src ? "R2 R3 ext sweep" : "R1 R3 tick sweep", cnt(), 32'(n >> ps));
          end

    wr_ctl(1, 1, 1, 0); wr_cnt(0);
    ext_clk = 1; cyc(1); chk("R4 async latency", cnt(), 1);
    ext_clk = 0; cyc(2);
    wr_ctl(1, 1, 0, 0); wr_cnt(0);
    ext_clk = 1; cyc(1); chk("R4 sync edge1", cnt(), 0);
    cyc(1); chk("R4 sync edge2", cnt(), 0);
    cyc(1); chk("R4 sync edge3", cnt(), 1);
    ext_clk = 0; cyc(3);

    wr_ctl(0, 0, 0, 0); wr_cnt(16'h0042);
    repeat (4) pulse();
    chk("R5 hold", cnt(), 16'h0042);

    wr_ctl(1, 0, 0, 2); wr_cnt(0);
    repeat (3) tick1();
    wr_cnt(16'h0010);
    repeat (3) tick1(); chk("R10 byte write restarts", cnt(), 16'h0010);
    tick1(); chk("R10 full period", cnt(), 16'h0011);
    repeat (3) tick1();
    wr_ctl(1, 0, 0, 1);
    tick1(); chk("R10 ps change restarts", cnt(), 16'h0011);
    tick1(); chk("R10 ps change period", cnt(), 16'h0012);

    wr_ctl(1, 0, 0, 0); wr_cnt(16'hFFFE);
    tick1(); chk("R7 no flag early", ovf_flag, 0);
    tick1(); chk("R7 wrap cnt", cnt(), 0); chk("R7 flag set", ovf_flag, 1);
    repeat (3) tick1(); chk("R7 sticky", ovf_flag, 1);
    wr_cnt(16'hFFFF);
    tick_en = 1; flag_clr = 1; cyc(1); tick_en = 0; flag_clr = 0;
    chk("R8 overflow wins", ovf_flag, 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R8 clear", ovf_flag, 0);

    wr_cnt(16'h0005);
    tick_en = 1; evt_clr = 1; cyc(1); tick_en = 0; evt_clr = 0;
    chk("R9 over increment", cnt(), 0);
    wr_cnt(16'hFFFF);
    tick_en = 1; evt_clr = 1; cyc(1); tick_en = 0; evt_clr = 0;
    chk("R9 no wrap flag", ovf_flag, 0);
    cnt_wdata = 8'h77; lo_we = 1; evt_clr = 1; cyc(1); lo_we = 0; evt_clr = 0;
    chk("R9 over write", cnt(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule